// File: doc/BRIEF.md
# Adaptive 4-bit Sample Block Decoder

This block expands compressed audio into signed samples. The input is a stream of 9-byte blocks. The first byte of each block is a header that selects a scale (shift) and one of four predictors, and carries two flags. Each of the eight bytes after it holds two signed 4-bit codes. Each code becomes one sample: the code is scaled, a prediction is added that is built from the two previous samples, and the sum is saturated and narrowed to 15 bits. That 15-bit value becomes the newest entry of the prediction history.

Work is driven by requests. While `grp_req` is high and the decoder is idle, it fetches just enough bytes for one group of four samples: the header when a block starts, then two data bytes. It then offers the group on a valid/ready output. Input back-pressure: a byte moves only in a cycle where `in_valid` and `in_ready` are both high, and `in_ready` is low while the decoder is idle or holding a group. Output back-pressure: once `out_valid` rises, the group stays unchanged until a cycle with `out_ready` high. No new byte is taken while a group waits. The prediction history belongs to one voice and survives groups, blocks and restarts.

Top module: `nibble_block_decoder`

## Requirements
- R1: A byte is consumed only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the decoder is fetching the header or the data bytes of a requested group.
- R2: While idle with `grp_req` low, the decoder keeps `in_ready` and `out_valid` low, whatever bytes are offered. Each time it leaves idle, it produces exactly one group of four samples.
- R3: The first byte of each block is the header: shift in bits [7:4], predictor in bits [3:2], loop flag in bit 1, end flag in bit 0. The header flags on `hdr_end`/`hdr_loop` change only when a header byte is taken.
- R4: Bits [7:4] of a data byte decode before bits [3:0]. In `out_samples`, lane k occupies bits [16k+15:16k], and lane 0 is the earliest sample of the group.
- R5: For a shift of 0 to 12, the scaled value is the sign-extended code shifted left by the shift, then arithmetically shifted right by one.
- R6: For a shift of 13 to 15, the scaled value is 0 for a non-negative code and -2048 for a negative code.
- R7: Predictor 0 yields the scaled value r. Predictor 1 yields r + p1 + ((-p1)>>4), where p1 is the newest history entry and >> is an arithmetic shift that rounds toward minus infinity.
- R8: Predictor 2 yields r + 2p1 + ((-3p1)>>5) - p2 + (p2>>4). Predictor 3 yields r + 2p1 + ((-13p1)>>6) - p2 + ((3p2)>>4). Here p2 is the entry older than p1.
- R9: Each sum is saturated to the signed 16-bit range, and its low 15 bits are kept as a signed value. That value enters the history and is output sign-extended to 16 bits.
- R10: The history carries over between groups and blocks. It starts at zero after reset, and `restart` leaves it unchanged.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_samples` hold. `in_ready` is low while `out_valid` is high.
- R12: `blk_done` is high exactly while the last group of a block is offered. `voice_stop` is high exactly while `blk_done` is high and the block's header has the end flag set with the loop flag clear.
- R13: `restart` returns the decoder to idle at the start of a block, so that the next byte taken is a header. The next cycle shows neither `in_ready` nor `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Return to the start of a block; history kept |
| grp_req | input | 1 | Request for the next group of four samples |
| in_valid | input | 1 | Byte on `in_byte` is valid |
| in_byte | input | 8 | Compressed stream byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | A decoded group is offered |
| out_ready | input | 1 | Consumer takes the group this cycle |
| out_samples | output | 64 | Four 16-bit samples, lane 0 in the low bits |
| blk_done | output | 1 | Offered group is the last of its block |
| hdr_end | output | 1 | End flag of the latest header |
| hdr_loop | output | 1 | Loop flag of the latest header |
| voice_stop | output | 1 | Last group of a block that ends without looping |

## Verification
The bench builds the decoder with its default parameters: four samples per group, 9-byte blocks, a 15-bit history and a 20-bit intermediate sum. With these values, a shift of 12 applied to repeated extreme codes under predictors 2 and 3 drives the sum past both 16-bit limits. That exercises saturation and the 15-bit wrap. Each of the shift ranges and each of the four predictors is reached within one block. Random stalls on both handshakes, a restart in the middle of a block, and end/loop flag combinations bring the hold rules, the block-done timing and the history carry-over within reach.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_OUT  = 2'd3
  } nbd_state_t;

  localparam int SHIFT_SAT_FROM = 13;
  localparam int SAT_NEG_RAW    = -2048;
endpackage

// File: rtl/nbd_sample_unit.sv
module nbd_sample_unit #(
  parameter int HW = 15,
  parameter int OW = 16,
  parameter int AW = 20
) (
  input  logic [3:0]    code,
  input  logic [3:0]    shamt,
  input  logic [1:0]    flt,
  input  logic [HW-1:0] p1,
  input  logic [HW-1:0] p2,
  output logic [HW-1:0] y
);
  import nbd_pkg::*;
  localparam int SAT_MAX = (1 << (OW - 1)) - 1;
  localparam int SAT_MIN = -(1 << (OW - 1));

  logic signed [AW-1:0] c_w, raw, a, b, sum;

  always_comb begin
    c_w = {{(AW-4){code[3]}}, code};
    a   = {{(AW-HW){p1[HW-1]}}, p1};
    b   = {{(AW-HW){p2[HW-1]}}, p2};
    if (shamt < 4'(SHIFT_SAT_FROM)) raw = (c_w <<< shamt) >>> 1;
    else                            raw = code[3] ? AW'(SAT_NEG_RAW) : '0;
    unique case (flt)
      2'd0: sum = raw;
      2'd1: sum = raw + a + ((-a) >>> 4);
      2'd2: sum = raw + (a <<< 1) + ((-(a + (a <<< 1))) >>> 5) - b + (b >>> 4);
      default: sum = raw + (a <<< 1) + ((-(a + (a <<< 2) + (a <<< 3))) >>> 6)
                     - b + ((b + (b <<< 1)) >>> 4);
    endcase
    // saturate to OW bits, then keep the low HW bits
    if (sum > AW'(SAT_MAX))      y = {HW{1'b1}};
    else if (sum < AW'(SAT_MIN)) y = '0;
    else                         y = sum[HW-1:0];
  end
endmodule

// File: rtl/nbd_seq.sv
module nbd_seq #(
  parameter int DATA_BYTES    = 8,
  parameter int BYTES_PER_GRP = 2,
  parameter int PW            = 4,
  parameter int SW            = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          grp_req,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          hdr_take,
  output logic          dat_take,
  output logic [SW-1:0] slot,
  output logic          out_valid,
  output logic          last_grp
);
  import nbd_pkg::*;

  nbd_state_t    st;
  logic [PW-1:0] pos;
  logic [SW-1:0] gbyte;

  always_comb begin
    in_ready  = (st == ST_HDR) || (st == ST_DATA);
    hdr_take  = in_valid && (st == ST_HDR);
    dat_take  = in_valid && (st == ST_DATA);
    out_valid = (st == ST_OUT);
    last_grp  = out_valid && (pos == PW'(DATA_BYTES));
    slot      = gbyte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st    <= ST_IDLE;
      pos   <= '0;
      gbyte <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (grp_req) st <= (pos == '0) ? ST_HDR : ST_DATA;
        ST_HDR:  if (in_valid) st <= ST_DATA;
        ST_DATA: if (in_valid) begin
          pos <= pos + PW'(1);
          if (gbyte == SW'(BYTES_PER_GRP - 1)) begin
            gbyte <= '0;
            st    <= ST_OUT;
          end else begin
            gbyte <= gbyte + SW'(1);
          end
        end
        default: if (out_ready) begin
          st <= ST_IDLE;
          if (pos == PW'(DATA_BYTES)) pos <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/nibble_block_decoder.sv
module nibble_block_decoder #(
  parameter int GRP_SAMPLES = 4,
  parameter int BLK_BYTES   = 9,
  parameter int HIST_W      = 15,
  parameter int OUT_W       = 16,
  parameter int ACC_W       = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       grp_req,
  input  logic                       in_valid,
  input  logic [7:0]                 in_byte,
  output logic                       in_ready,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [GRP_SAMPLES*OUT_W-1:0] out_samples,
  output logic                       blk_done,
  output logic                       hdr_end,
  output logic                       hdr_loop,
  output logic                       voice_stop
);
  localparam int NIB_PER_BYTE  = 2;
  localparam int DATA_BYTES    = BLK_BYTES - 1;
  localparam int BYTES_PER_GRP = GRP_SAMPLES / NIB_PER_BYTE;
  localparam int PW            = $clog2(DATA_BYTES + 1);
  localparam int SW            = (BYTES_PER_GRP > 1) ? $clog2(BYTES_PER_GRP) : 1;
  localparam int LW            = $clog2(GRP_SAMPLES);

  logic              hdr_take, dat_take, last_grp;
  logic [SW-1:0]     slot;
  logic [3:0]        hdr_shift;
  logic [1:0]        hdr_flt;
  logic [HIST_W-1:0] hist_p1, hist_p2;
  logic [HIST_W-1:0] ch_y [NIB_PER_BYTE];
  logic [OUT_W-1:0]  lane_q [GRP_SAMPLES];

  nbd_seq #(
    .DATA_BYTES(DATA_BYTES), .BYTES_PER_GRP(BYTES_PER_GRP), .PW(PW), .SW(SW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart), .grp_req(grp_req),
    .in_valid(in_valid), .out_ready(out_ready), .in_ready(in_ready),
    .hdr_take(hdr_take), .dat_take(dat_take), .slot(slot),
    .out_valid(out_valid), .last_grp(last_grp)
  );

  // nibble chain: high nibble first, each stage sees the previous result
  for (genvar i = 0; i < NIB_PER_BYTE; i++) begin : g_nib
    logic [HIST_W-1:0] pa, pb;
    if (i == 0) begin : g_first
      assign pa = hist_p1;
      assign pb = hist_p2;
    end else if (i == 1) begin : g_second
      assign pa = ch_y[0];
      assign pb = hist_p1;
    end else begin : g_rest
      assign pa = ch_y[i-1];
      assign pb = ch_y[i-2];
    end
    nbd_sample_unit #(.HW(HIST_W), .OW(OUT_W), .AW(ACC_W)) u_unit (
      .code(in_byte[8-4*(i+1) +: 4]), .shamt(hdr_shift), .flt(hdr_flt),
      .p1(pa), .p2(pb), .y(ch_y[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_shift <= '0;
      hdr_flt   <= '0;
      hdr_end   <= 1'b0;
      hdr_loop  <= 1'b0;
    end else if (hdr_take) begin
      hdr_shift <= in_byte[7:4];
      hdr_flt   <= in_byte[3:2];
      hdr_loop  <= in_byte[1];
      hdr_end   <= in_byte[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_p1 <= '0;
      hist_p2 <= '0;
      for (int k = 0; k < GRP_SAMPLES; k++) lane_q[k] <= '0;
    end else if (dat_take && !restart) begin
      hist_p1 <= ch_y[NIB_PER_BYTE-1];
      hist_p2 <= ch_y[NIB_PER_BYTE-2];
      for (int i = 0; i < NIB_PER_BYTE; i++)
        lane_q[LW'(int'(slot) * NIB_PER_BYTE + i)] <=
          {{(OUT_W-HIST_W){ch_y[i][HIST_W-1]}}, ch_y[i]};
    end
  end

  for (genvar k = 0; k < GRP_SAMPLES; k++) begin : g_pack
    assign out_samples[k*OUT_W +: OUT_W] = lane_q[k];
  end

  assign blk_done   = last_grp;
  assign voice_stop = last_grp && hdr_end && !hdr_loop;
endmodule

// File: rtl/nbd_checker.sv
module nbd_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         restart,
  input logic         grp_req,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_samples,
  input logic         blk_done,
  input logic         hdr_end,
  input logic         hdr_loop
);
  a_r11_hold_group: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !restart |=> out_valid && $stable(out_samples));

  a_r11_no_fetch_while_offered: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r12_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> out_valid);

  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable({hdr_end, hdr_loop}));

  a_r13_restart_idle: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_valid && !in_ready);

  a_r2_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_req && !in_ready && !out_valid |=> !in_ready && !out_valid);
endmodule

bind nibble_block_decoder nbd_checker #(.W(GRP_SAMPLES*OUT_W)) u_chk (.*);

// File: tb/nibble_block_decoder_tb_top.sv
module nibble_block_decoder_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, restart, grp_req, in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  in_byte;
  logic [63:0] out_samples;
  logic blk_done, hdr_end, hdr_loop, voice_stop;

  nibble_block_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .grp_req(grp_req),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_samples(out_samples),
    .blk_done(blk_done), .hdr_end(hdr_end), .hdr_loop(hdr_loop),
    .voice_stop(voice_stop)
  );

  logic [7:0] bq[$];
  int exp_s[$];
  bit exp_last[$], exp_end[$], exp_loop[$];
  int pend[$];
  int m_pos, m_sh, m_f, m_h1, m_h2;
  bit m_loop, m_end;
  int n_chk, n_fail, cyc, seed;
  bit abort;
  logic [15:0] lf;

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int dec_one(int nib);
    int c, raw, s;
    c = (nib >= 8) ? nib - 16 : nib;
    if (m_sh <= 12) raw = (c <<< m_sh) >>> 1;
    else            raw = (c < 0) ? -2048 : 0;
    case (m_f)
      0: s = raw;
      1: s = raw + m_h1 + ((-m_h1) >>> 4);
      2: s = raw + 2*m_h1 + ((-3*m_h1) >>> 5) - m_h2 + (m_h2 >>> 4);
      default: s = raw + 2*m_h1 + ((-13*m_h1) >>> 6) - m_h2 + ((3*m_h2) >>> 4);
    endcase
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    s = s & 32'h7fff;
    if (s >= 16384) s -= 32768;
    m_h2 = m_h1;
    m_h1 = s;
    return s;
  endfunction

  task automatic model_byte(logic [7:0] b);
    if (m_pos == 0) begin
      m_sh = int'(b[7:4]); m_f = int'(b[3:2]); m_loop = b[1]; m_end = b[0];
      m_pos = 1;
    end else begin
      pend.push_back(dec_one(int'(b[7:4])));
      pend.push_back(dec_one(int'(b[3:0])));
      m_pos++;
      if (pend.size() == 4) begin
        for (int k = 0; k < 4; k++) exp_s.push_back(pend[k]);
        pend.delete();
        exp_last.push_back(m_pos == 9);
        exp_end.push_back(m_end);
        exp_loop.push_back(m_loop);
        if (m_pos == 9) m_pos = 0;
      end
    end
  endtask

  // fill: -1 random, -2 ascending nibbles, else constant byte
  task automatic push_block(int sh, int f, bit lp, bit en, int fill);
    bq.push_back({sh[3:0], f[1:0], lp, en});
    for (int i = 0; i < 8; i++) begin
      if (fill == -1) begin
        seed = seed * 1103515245 + 12345;
        bq.push_back(seed[23:16]);
      end else if (fill == -2) begin
        bq.push_back({4'(2*i), 4'(2*i+1)});
      end else begin
        bq.push_back(fill[7:0]);
      end
    end
  endtask

  task automatic step(bit req, bit rs);
    @(negedge clk);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    grp_req   = req;
    restart   = rs;
    in_valid  = (bq.size() > 0) && (lf[0] | lf[3]);
    in_byte   = (bq.size() > 0) ? bq[0] : 8'h00;
    out_ready = lf[5] | lf[7];
    #1;
    if (rs) begin m_pos = 0; pend.delete(); end
    if (in_valid && in_ready && !rs) model_byte(bq.pop_front());
    if (out_valid && out_ready && !rs) begin
      if (exp_last.size() == 0) begin
        chk(1'b0, "R2 unexpected group", 1, 0);
      end else begin
        for (int k = 0; k < 4; k++)
          chk(int'($signed(out_samples[k*16 +: 16])) == exp_s[k],
              $sformatf("R4 R5 R6 R7 R8 R9 R10 lane%0d", k),
              int'($signed(out_samples[k*16 +: 16])), exp_s[k]);
        chk(blk_done == exp_last[0], "R12 blk_done", int'(blk_done), int'(exp_last[0]));
        chk(hdr_end == exp_end[0] && hdr_loop == exp_loop[0], "R3 header flags",
            int'({hdr_end, hdr_loop}), int'({exp_end[0], exp_loop[0]}));
        chk(voice_stop == (exp_last[0] && exp_end[0] && !exp_loop[0]), "R12 voice_stop",
            int'(voice_stop), int'(exp_last[0] && exp_end[0] && !exp_loop[0]));
        for (int k = 0; k < 4; k++) void'(exp_s.pop_front());
        void'(exp_last.pop_front());
        void'(exp_end.pop_front());
        void'(exp_loop.pop_front());
      end
    end
    cyc++;
    if (cyc > 150000 && !abort) begin
      abort = 1'b1;
      chk(1'b0, "R1 watchdog", cyc, 150000);
    end
  endtask

  task automatic drain();
    while (!abort && (bq.size() > 0 || exp_last.size() > 0)) step(1'b1, 1'b0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; abort = 1'b0; seed = 7; lf = 16'hACE1;
    m_pos = 0; m_h1 = 0; m_h2 = 0; m_sh = 0; m_f = 0;
    rst_n = 1'b0; restart = 1'b0; grp_req = 1'b0; in_valid = 1'b0;
    in_byte = 8'h00; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    chk(!out_valid && !in_ready && !blk_done && !hdr_end && !hdr_loop,
        "R2 reset state", int'({out_valid, in_ready, blk_done, hdr_end, hdr_loop}), 0);

    push_block(0, 0, 0, 0, -2);
    push_block(4, 1, 0, 0, -1);
    push_block(12, 2, 0, 0, 8'h77);
    push_block(12, 3, 0, 0, 8'h88);
    push_block(13, 0, 1, 1, 8'h8F);
    push_block(15, 1, 0, 1, 8'hC3);
    push_block(9, 3, 1, 0, -1);
    push_block(2, 2, 0, 0, -1);
    push_block(12, 3, 0, 0, 8'h77);
    drain();

    // R2: no request means no fetch and no output, bytes pending
    step(1'b0, 1'b1);
    push_block(6, 1, 0, 1, -1);
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b0);
      chk(!in_ready && !out_valid, "R2 idle without request",
          int'({in_ready, out_valid}), 0);
      chk(bq.size() == 9, "R1 no byte consumed while idle", bq.size(), 9);
    end
    drain();

    // R13: restart in the middle of a block, history kept (R10)
    bq.push_back({4'd8, 2'd2, 1'b0, 1'b0});
    for (int i = 0; i < 4; i++) bq.push_back(8'h5A);
    m_pos = 0;
    drain();
    step(1'b0, 1'b1);
    chk(!in_ready && !out_valid, "R13 restart returns idle",
        int'({in_ready, out_valid}), 0);
    push_block(3, 3, 1, 1, -1);
    push_block(11, 2, 0, 1, -1);
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule